// File: doc/BRIEF.md
# Power Gate Segment Sequencer

This block turns the header transistor segments of a gated power domain on or off one at a time, so that the inrush current when power is restored, or the voltage step when it is removed, is spread over time. A single start pulse, together with a direction bit, launches a fixed walk of twelve steps. The walk runs from the highest segment index down to the lowest. Each step drives one segment enable to the target level, and the sequencer then waits for a programmable number of clock cycles before it moves to the next step.

Each direction has its own pair of wait lengths and its own 32-bit selection word. For every step, one bit of the word picks which of the two wait lengths follows that step. The direction, the twelve selection bits and both wait lengths are captured when the start is accepted. Later changes on those inputs therefore do not affect a walk that is already running. The block reports progress with a busy level and a one-cycle completion pulse. Segment enables keep their values between walks.

Top module: `pfet_step_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after a reset edge, `seg_en` is all zeros and both `busy` and `done` are low.
- R2: A `start` that is sampled high while the block is idle is accepted at that clock edge. The step with index 11 is applied at that same edge, and `busy` is high after it.
- R3: Steps are applied in strictly descending index order, 11, 10, ... 0, and exactly one segment enable is written per step.
- R4: With `dir_up`=1 a step k sets `seg_en[k]` to 1, and with `dir_up`=0 it clears `seg_en[k]` to 0. Enables whose step has not yet been reached keep their previous values.
- R5: The wait after step k is chosen by bit [20+k] of the direction's selection word, so step 11 uses bit 31. A bit value of 0 selects wait length 0 and a value of 1 selects wait length 1. A wait length of d places step k-1 exactly d+1 cycles after step k. Bits [19:0] of the word have no effect.
- R6: A wait length of 0 applies the next step in the cycle immediately after the current one.
- R7: A power-up walk uses only `up_sel`, `up_dly0` and `up_dly1`. A power-down walk uses only `dn_sel`, `dn_dly0` and `dn_dly1`.
- R8: `done` is high for exactly one cycle, at the edge that ends the wait after step 0. `busy` falls at that same edge.
- R9: A `start` that arrives while `busy` is high is ignored. The running walk keeps its direction and its timing.
- R10: The direction, the selection bits and the wait lengths are captured when the start is accepted. Changes to those inputs while busy do not alter the running walk.
- R11: Asserting `rst` in the middle of a walk stops it at the next edge, with all enables cleared and `busy` low. A new walk can be started afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch request, one cycle, taken only when idle |
| dir_up | input | 1 | 1 = power-up walk, 0 = power-down walk |
| up_sel | input | 32 | Power-up selection word, bits [31:20] pick the wait for steps 11..0 |
| dn_sel | input | 32 | Power-down selection word, same bit layout |
| up_dly0 | input | 8 | Power-up wait length 0, in cycles |
| up_dly1 | input | 8 | Power-up wait length 1, in cycles |
| dn_dly0 | input | 8 | Power-down wait length 0, in cycles |
| dn_dly1 | input | 8 | Power-down wait length 1, in cycles |
| seg_en | output | 12 | Segment enable vector |
| busy | output | 1 | High while a walk is in progress |
| done | output | 1 | One-cycle pulse when a walk completes |

## Verification
The scoreboard predicts, cycle by cycle, the full enable vector together with `busy` and `done` for each walk. Any ordering error, wrong selection bit or off-by-one in a wait therefore shows up at the exact cycle it occurs.

The first power-up walk uses a mixed selection word, with a zero wait length and a nonzero one, and with garbage in the low 20 bits. This separates the correct bit mapping from a reversed or shifted mapping. A power-down walk then runs with swapped-in delay values while the power-up inputs are left set, which shows whether the direction picks the right word and the right pair of wait lengths. A third walk is disturbed by a mid-walk start pulse and by changes to its configuration inputs. A fourth walk, with all wait lengths zero, shows back-to-back steps. A reset issued in the middle of a walk is followed by a fresh walk, to show that recovery is clean.

// File: rtl/pfet_seq_pkg.sv
package pfet_seq_pkg;
  localparam int unsigned NSTEP_DEF = 12;
  localparam int unsigned SEL_W_DEF = 32;
  localparam int unsigned DLY_W_DEF = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/pfet_dly_timer.sv
module pfet_dly_timer #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             expired
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R5: a loaded wait counts down by one each cycle until it reaches zero
  p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == DLY_W'($past(cnt_q) - 1'b1)));

  // R6: a zero-length wait is seen as expired on the very next cycle
  p_zero_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (load && load_val == '0) |=> expired);
endmodule

// File: rtl/pfet_step_ctrl.sv
module pfet_step_ctrl
  import pfet_seq_pkg::*;
#(
  parameter int unsigned NSTEP  = 12,
  parameter int unsigned STEP_W = $clog2(NSTEP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              expired,
  output logic              start_acc,
  output logic              apply,
  output logic [STEP_W-1:0] apply_idx,
  output logic              busy,
  output logic              done
);
  localparam logic [STEP_W-1:0] TOP_STEP = STEP_W'(NSTEP - 1);

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q;
  logic              advance;
  logic              finish;

  always_comb begin
    start_acc = start && (state_q == ST_IDLE);
    advance   = (state_q == ST_WAIT) && expired && (step_q != '0);
    finish    = (state_q == ST_WAIT) && expired && (step_q == '0);
    apply     = start_acc || advance;
    apply_idx = start_acc ? TOP_STEP : (step_q - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (start_acc)   state_q <= ST_WAIT;
      else if (finish) state_q <= ST_IDLE;
      if (apply)       step_q  <= apply_idx;
    end
  end

  assign busy = (state_q == ST_WAIT);
  assign done = done_q;

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: completion only follows a cycle that was busy, and busy is low with it
  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));

  // R3: every step after the first is one below the previous one
  p_descend_r3: assert property (@(posedge clk) disable iff (rst)
    advance |=> (step_q == STEP_W'($past(step_q) - 1'b1)));

  // R3: the step index stays inside the walk
  p_step_range_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (step_q <= TOP_STEP));

  // R9: a start while busy does not bring the walk back to the top step
  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !finish && step_q != TOP_STEP) |=> (step_q != TOP_STEP));
endmodule

// File: rtl/pfet_seg_bank.sv
module pfet_seg_bank #(
  parameter int unsigned NSTEP  = 12,
  parameter int unsigned STEP_W = $clog2(NSTEP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              apply,
  input  logic [STEP_W-1:0] idx,
  input  logic              val,
  output logic [NSTEP-1:0]  seg_en
);
  logic [NSTEP-1:0] seg_q;

  for (genvar g = 0; g < NSTEP; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst)                                  seg_q[g] <= 1'b0;
      else if (apply && idx == STEP_W'(g))      seg_q[g] <= val;
    end
  end

  assign seg_en = seg_q;

  // R4: enables hold when no step is applied
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !apply |=> $stable(seg_en));

  // R3: a step changes at most one enable
  p_one_segment_r3: assert property (@(posedge clk) disable iff (rst)
    apply |=> ($countones(seg_en ^ $past(seg_en)) <= 1));
endmodule

// File: rtl/pfet_step_seq.sv
module pfet_step_seq
  import pfet_seq_pkg::*;
#(
  parameter int unsigned NSTEP = NSTEP_DEF,
  parameter int unsigned SEL_W = SEL_W_DEF,
  parameter int unsigned DLY_W = DLY_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             dir_up,
  input  logic [SEL_W-1:0] up_sel,
  input  logic [SEL_W-1:0] dn_sel,
  input  logic [DLY_W-1:0] up_dly0,
  input  logic [DLY_W-1:0] up_dly1,
  input  logic [DLY_W-1:0] dn_dly0,
  input  logic [DLY_W-1:0] dn_dly1,
  output logic [NSTEP-1:0] seg_en,
  output logic             busy,
  output logic             done
);
  localparam int unsigned STEP_W  = $clog2(NSTEP);
  localparam int unsigned SEL_LSB = SEL_W - NSTEP;

  logic              start_acc;
  logic              apply;
  logic [STEP_W-1:0] apply_idx;
  logic              expired;

  logic              dir_q;
  logic [NSTEP-1:0]  sel_q;
  logic [DLY_W-1:0]  d0_q, d1_q;

  logic [NSTEP-1:0]  live_sel;
  logic [DLY_W-1:0]  live_d0, live_d1;
  logic              cur_dir;
  logic [NSTEP-1:0]  cur_sel;
  logic [DLY_W-1:0]  cur_d0, cur_d1;
  logic [DLY_W-1:0]  wait_len;

  always_comb begin
    live_sel = dir_up ? up_sel[SEL_W-1:SEL_LSB] : dn_sel[SEL_W-1:SEL_LSB];
    live_d0  = dir_up ? up_dly0 : dn_dly0;
    live_d1  = dir_up ? up_dly1 : dn_dly1;
    cur_dir  = start_acc ? dir_up   : dir_q;
    cur_sel  = start_acc ? live_sel : sel_q;
    cur_d0   = start_acc ? live_d0  : d0_q;
    cur_d1   = start_acc ? live_d1  : d1_q;
    wait_len = cur_sel[apply_idx] ? cur_d1 : cur_d0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= 1'b0;
      sel_q <= '0;
      d0_q  <= '0;
      d1_q  <= '0;
    end else if (start_acc) begin
      dir_q <= dir_up;
      sel_q <= live_sel;
      d0_q  <= live_d0;
      d1_q  <= live_d1;
    end
  end

  pfet_step_ctrl #(.NSTEP(NSTEP), .STEP_W(STEP_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .expired   (expired),
    .start_acc (start_acc),
    .apply     (apply),
    .apply_idx (apply_idx),
    .busy      (busy),
    .done      (done)
  );

  pfet_dly_timer #(.DLY_W(DLY_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (apply),
    .load_val (wait_len),
    .expired  (expired)
  );

  pfet_seg_bank #(.NSTEP(NSTEP), .STEP_W(STEP_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .apply  (apply),
    .idx    (apply_idx),
    .val    (cur_dir),
    .seg_en (seg_en)
  );

  // R10: captured configuration is frozen for the whole walk
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(sel_q) && $stable(dir_q) && $stable(d0_q) && $stable(d1_q)));

  // R2: an accepted start makes the block busy on the next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

// File: tb/pfet_step_seq_tb.sv
module pfet_step_seq_tb;
  localparam int NSTEP = 12;
  localparam int SEL_W = 32;
  localparam int DLY_W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             dir_up = 1'b0;
  logic [SEL_W-1:0] up_sel = '0, dn_sel = '0;
  logic [DLY_W-1:0] up_dly0 = '0, up_dly1 = '0, dn_dly0 = '0, dn_dly1 = '0;
  logic [NSTEP-1:0] seg_en;
  logic             busy, done;

  pfet_step_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .dir_up(dir_up),
    .up_sel(up_sel), .dn_sel(dn_sel),
    .up_dly0(up_dly0), .up_dly1(up_dly1), .dn_dly0(dn_dly0), .dn_dly1(dn_dly1),
    .seg_en(seg_en), .busy(busy), .done(done)
  );

  typedef struct {
    logic [NSTEP-1:0] seg;
    logic             bsy;
    logic             dn;
    string            tag;
  } exp_t;

  exp_t             expq[$];
  int               checks = 0;
  int               errors = 0;
  logic [NSTEP-1:0] seg_m = '0;
  bit               finished = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: one expected item per cycle, compared away from the edge
  always @(negedge clk) begin
    exp_t e;
    if (expq.size() > 0) begin
      e = expq.pop_front();
      chk(e.tag, "seg_en", 32'(seg_en), 32'(e.seg));
      chk(e.tag, "busy",   32'(busy),   32'(e.bsy));
      chk(e.tag, "done",   32'(done),   32'(e.dn));
    end
  end

  task automatic push_item(input logic [NSTEP-1:0] s, input logic b,
                           input logic d, input string tag);
    exp_t e;
    e.seg = s; e.bsy = b; e.dn = d; e.tag = tag;
    expq.push_back(e);
  endtask

  // model of a full walk, from the sample after the accepting edge
  task automatic push_walk(input bit up, input logic [SEL_W-1:0] sel,
                           input int d0, input int d1, input string tag);
    for (int k = NSTEP - 1; k >= 0; k--) begin
      int dk;
      seg_m[k] = up;
      dk = sel[20 + k] ? d1 : d0;
      for (int c = 0; c <= dk; c++) push_item(seg_m, 1'b1, 1'b0, tag);
    end
    push_item(seg_m, 1'b0, 1'b1, tag);
    push_item(seg_m, 1'b0, 1'b0, tag);
  endtask

  task automatic launch(input bit up, input logic [SEL_W-1:0] sel,
                        input int d0, input int d1, input string tag);
    @(posedge clk); #1;
    dir_up = up;
    if (up) begin up_sel = sel; up_dly0 = DLY_W'(d0); up_dly1 = DLY_W'(d1); end
    else    begin dn_sel = sel; dn_dly0 = DLY_W'(d0); dn_dly1 = DLY_W'(d1); end
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    push_walk(up, sel, d0, d1, tag);
  endtask

  task automatic drain();
    while (expq.size() > 0) @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "seg_en", 32'(seg_en), 32'h0);
    chk("R1", "busy",   32'(busy),   32'h0);
    chk("R1", "done",   32'(done),   32'h0);
    @(posedge clk); #1;
    rst = 1'b0;

    // R2 R3 R5 R6: mixed select word, zero and nonzero waits, low bits garbage
    dn_dly0 = 8'd9; dn_dly1 = 8'd9; dn_sel = 32'hFFFF_FFFF;
    launch(1'b1, 32'hA5A3_C917, 0, 3, "R2 R3 R5 R6 power-up");
    drain();

    // R4 R7: power-down uses its own word and delays; up inputs left set
    up_dly0 = 8'd6; up_dly1 = 8'd6;
    launch(1'b0, 32'h3C9F_FFFF, 2, 0, "R4 R7 power-down");
    drain();

    // R9 R10: start and config changes during a walk are ignored
    launch(1'b1, 32'hFFF0_0000, 4, 1, "R9 R10 busy-ignore");
    repeat (4) @(posedge clk);
    #1;
    start = 1'b1; dir_up = 1'b0;
    up_sel = 32'h0; up_dly1 = 8'd9; dn_dly0 = 8'd0;
    @(posedge clk); #1;
    start = 1'b0;
    drain();

    // R6 R8: all zero waits, twelve back-to-back steps then done
    launch(1'b0, 32'h0000_0000, 0, 5, "R6 R8 back-to-back");
    drain();

    // R11: reset in the middle of a walk
    @(posedge clk); #1;
    dir_up = 1'b1; up_sel = 32'h0; up_dly0 = 8'd3; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R11", "seg_en", 32'(seg_en), 32'h0);
    chk("R11", "busy",   32'(busy),   32'h0);
    chk("R11", "done",   32'(done),   32'h0);
    rst = 1'b0;
    seg_m = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "busy idle", 32'(busy), 32'h0);
    launch(1'b1, 32'h5550_0000, 1, 0, "R11 R2 after-reset");
    drain();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule